// File: doc/BRIEF.md
# Sprite Scanline Pixel Renderer

This block draws a single row of one sprite into a line buffer while a scanline is being built. It accepts a sprite descriptor together with the current line number. First it checks whether the sprite covers that line. If it does, it works out which stored row to draw and the byte address where that row starts. It then reads the row's pattern bytes one at a time over a valid/ready read port.

Each pixel is unpacked from the byte stream at the depth the descriptor selects. Indexed pixels go through an external palette port; direct pixels skip the palette. Every pixel is written as RGB565 plus a blend flag to its horizontal position in the line buffer. The control logic issues strobes to a datapath that holds the descriptor, a bit accumulator and the pixel column counter.

A layer sequencer drives one descriptor per sprite and waits for the done pulse before it offers the next one.

Top module: `sprite_row_render`

## Requirements
- R1: `startReady` is high only while the block is idle. A descriptor is taken on a cycle where `startValid` and `startReady` are both high. From that point `startReady` stays low until the cycle after the done pulse.
- R2: Let D = `lineNum` − `sprY`. The sprite covers the line only when D lies between 0 and H−1, where H = (`sprHCode`+1)·8. If it does not, the block makes no read, writes nothing and still raises `done`.
- R3: The row drawn is D, or H−1−D when `sprFlipV` is set. Rows are stored one after another, each (`sprWCode`+1)·bpp bytes long. The block reads exactly that many bytes, starting at `sprBase` + row·stride, at consecutive increasing addresses.
- R4: `sprMode` encodes the pixel depth: 0 = 1 bit, 1 = 4 bits, 2 = 5 bits, 3 = 6 bits and 4 = 8 bits (all indexed), 5 = 16-bit direct, and 6 or 7 = 8-bit indexed. Pixels are packed MSB-first and may straddle byte boundaries.
- R5: For an indexed pixel, the block drives the pixel value on `palIdx` and writes `palData` with `palBlend` as the blend flag. A pixel whose index is 0 is transparent and is not written.
- R6: A direct pixel is 16 bits, with its first byte as the high byte. It is written unchanged with blend flag 0, and a value of 0 is still written.
- R7: Pixel c in fetch order (c = 0 … W−1, W = (`sprWCode`+1)·8) goes to column `sprX`+c. When `sprFlipH` is set it goes to column `sprX`+W−1−c instead.
- R8: A pixel whose column is at or beyond LINE_W is not written.
- R9: While `memReqValid` waits for `memReqReady`, it stays high and `memReqAddr` holds. Only one read is outstanding at a time, and the next request follows the response to the previous one.
- R10: `done` is a one-cycle pulse. It comes one cycle after the row's last pixel slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Descriptor offered |
| startReady | output | 1 | Block idle, descriptor can be taken |
| sprBase | input | ADDR_W | Byte address of the sprite's first row |
| sprX | input | X_W | Leftmost column of the sprite |
| sprY | input | Y_W | Top line of the sprite |
| sprWCode | input | SZ_W | Width in 8-dot units minus one |
| sprHCode | input | SZ_W | Height in 8-dot units minus one |
| sprMode | input | 3 | Pixel depth / direct colour select |
| sprFlipH | input | 1 | Mirror horizontally |
| sprFlipV | input | 1 | Mirror vertically |
| lineNum | input | Y_W | Scanline being built |
| memReqValid | output | 1 | Pattern read request |
| memReqReady | input | 1 | Request accepted |
| memReqAddr | output | ADDR_W | Pattern byte address |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 8 | Pattern byte |
| palIdx | output | 8 | Palette index of the current pixel |
| palData | input | 16 | RGB565 colour for `palIdx` (same cycle) |
| palBlend | input | 1 | Blend flag for `palIdx` (same cycle) |
| lbWe | output | 1 | Line-buffer write enable |
| lbAddr | output | clog2(LINE_W) | Line-buffer column |
| lbData | output | 16 | RGB565 pixel |
| lbBlend | output | 1 | Pixel blend flag |
| done | output | 1 | Row finished |

## Verification
The assertions check several rules on every cycle. The request address must hold while the read port stalls. No indexed write may carry a zero index. No write may happen on a line the sprite misses. The accumulator must never give out more bits than it holds, and `done` must be a single pulse that returns the block to idle. The bench's scenarios show what depends on a reference model of the bit stream. That covers pixel values at each depth, the placement of rows and columns under each mirror setting, clipping at the buffer's edge, and the exact count and order of byte reads.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PIX,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } spr_state_t;

  typedef struct packed {
    logic load;     // capture descriptor
    logic reqAcc;   // read request accepted, advance address
    logic rspTake;  // append returned byte to accumulator
    logic emit;     // consume one pixel
  } spr_strobe_t;

  function automatic logic [4:0] modeBpp(input logic [2:0] mode);
    case (mode)
      3'd0:    return 5'd1;
      3'd1:    return 5'd4;
      3'd2:    return 5'd5;
      3'd3:    return 5'd6;
      3'd5:    return 5'd16;
      default: return 5'd8;
    endcase
  endfunction

endpackage

// File: rtl/spr_row_dp.sv
module spr_row_dp
  import spr_pkg::*;
#(
  parameter int LINE_W = 64,
  parameter int ADDR_W = 24,
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int SZ_W   = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  spr_strobe_t               stb,
  input  logic [ADDR_W-1:0]         sprBase,
  input  logic [X_W-1:0]            sprX,
  input  logic [Y_W-1:0]            sprY,
  input  logic [SZ_W-1:0]           sprWCode,
  input  logic [SZ_W-1:0]           sprHCode,
  input  logic [2:0]                sprMode,
  input  logic                      sprFlipH,
  input  logic                      sprFlipV,
  input  logic [Y_W-1:0]            lineNum,
  input  logic [7:0]                memRspData,
  input  logic [15:0]               palData,
  input  logic                      palBlend,
  output logic                      hit,
  output logic                      haveBits,
  output logic                      lastPix,
  output logic [ADDR_W-1:0]         memReqAddr,
  output logic [7:0]                palIdx,
  output logic                      lbWe,
  output logic [$clog2(LINE_W)-1:0] lbAddr,
  output logic [15:0]               lbData,
  output logic                      lbBlend
);

  localparam int LB_AW  = $clog2(LINE_W);
  localparam int DIM_W  = SZ_W + 4;
  localparam int STR_W  = SZ_W + 6;
  localparam int PROD_W = DIM_W + STR_W;
  localparam int CMP_W  = (Y_W + 1 > DIM_W) ? Y_W + 1 : DIM_W;
  localparam int POS_W  = ((X_W > DIM_W) ? X_W : DIM_W) + 1;

  // descriptor decode at load time
  logic [4:0]        bppIn;
  logic              directIn;
  logic [DIM_W-1:0]  wIn, hIn, rowIn;
  logic [Y_W:0]      diffIn;
  logic              hitIn;
  logic [STR_W-1:0]  strideIn;
  logic [PROD_W-1:0] prodIn;
  logic [ADDR_W-1:0] addrIn;

  assign bppIn    = modeBpp(sprMode);
  assign directIn = (bppIn == 5'd16);
  assign wIn      = (DIM_W'(sprWCode) + DIM_W'(1)) << 3;
  assign hIn      = (DIM_W'(sprHCode) + DIM_W'(1)) << 3;
  assign diffIn   = {1'b0, lineNum} - {1'b0, sprY};
  assign hitIn    = !diffIn[Y_W] && (CMP_W'(diffIn) < CMP_W'(hIn));
  assign rowIn    = sprFlipV ? (hIn - DIM_W'(1) - DIM_W'(diffIn)) : DIM_W'(diffIn);
  assign strideIn = (STR_W'(sprWCode) + STR_W'(1)) * STR_W'(bppIn);
  assign prodIn   = PROD_W'(rowIn) * PROD_W'(strideIn);
  assign addrIn   = sprBase + ADDR_W'(prodIn);

  // working state
  logic [ADDR_W-1:0] addrQ;
  logic [23:0]       accQ;
  logic [4:0]        availQ;
  logic [DIM_W-1:0]  colQ, widthQ;
  logic [X_W-1:0]    xQ;
  logic [4:0]        bppQ;
  logic              directQ, flipHQ, hitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      accQ    <= '0;
      availQ  <= '0;
      colQ    <= '0;
      widthQ  <= '0;
      xQ      <= '0;
      bppQ    <= 5'd1;
      directQ <= 1'b0;
      flipHQ  <= 1'b0;
      hitQ    <= 1'b0;
    end else if (stb.load) begin
      addrQ   <= addrIn;
      accQ    <= '0;
      availQ  <= '0;
      colQ    <= '0;
      widthQ  <= wIn;
      xQ      <= sprX;
      bppQ    <= bppIn;
      directQ <= directIn;
      flipHQ  <= sprFlipH;
      hitQ    <= hitIn;
    end else begin
      if (stb.reqAcc) addrQ <= addrQ + ADDR_W'(1);
      if (stb.rspTake) begin
        accQ   <= accQ | ({memRspData, 16'h0000} >> availQ);
        availQ <= availQ + 5'd8;
      end else if (stb.emit) begin
        accQ   <= accQ << bppQ;
        availQ <= availQ - bppQ;
        colQ   <= colQ + DIM_W'(1);
      end
    end
  end

  // pixel extraction and placement
  logic [15:0]      rawPix;
  logic [DIM_W-1:0] colOff;
  logic [POS_W-1:0] xPos;
  logic             inRange, clear;

  assign rawPix  = accQ[23:8] >> (5'd16 - bppQ);
  assign palIdx  = rawPix[7:0];
  assign clear   = !directQ && (palIdx == 8'd0);
  assign colOff  = flipHQ ? (widthQ - DIM_W'(1) - colQ) : colQ;
  assign xPos    = POS_W'(xQ) + POS_W'(colOff);
  assign inRange = xPos < POS_W'(LINE_W);

  assign hit        = hitQ;
  assign haveBits   = availQ >= bppQ;
  assign lastPix    = colQ == (widthQ - DIM_W'(1));
  assign memReqAddr = addrQ;
  assign lbWe       = stb.emit && inRange && !clear;
  assign lbAddr     = xPos[LB_AW-1:0];
  assign lbData     = directQ ? rawPix : palData;
  assign lbBlend    = directQ ? 1'b0 : palBlend;

  AST_NO_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    lbWe && !directQ |-> palIdx != 8'd0); // R5
  AST_NO_WRITE_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    lbWe |-> hitQ); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.emit |-> availQ >= bppQ); // R4
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stb.rspTake |-> availQ <= 5'd15); // R4

endmodule

// File: rtl/spr_row_ctrl.sv
module spr_row_ctrl
  import spr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        hit,
  input  logic        haveBits,
  input  logic        lastPix,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output spr_strobe_t stb,
  output logic        startReady,
  output logic        memReqValid,
  output logic        done
);

  spr_state_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    case (stateQ)
      ST_IDLE: if (startValid) begin
        stb.load = 1'b1;
        stateD   = ST_PIX;
      end
      ST_PIX: begin
        if (!hit) stateD = ST_DONE;
        else if (haveBits) begin
          stb.emit = 1'b1;
          if (lastPix) stateD = ST_DONE;
        end else stateD = ST_REQ;
      end
      ST_REQ: if (memReqReady) begin
        stb.reqAcc = 1'b1;
        stateD     = ST_WAIT;
      end
      ST_WAIT: if (memRspValid) begin
        stb.rspTake = 1'b1;
        stateD      = ST_PIX;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign startReady  = stateQ == ST_IDLE;
  assign memReqValid = stateQ == ST_REQ;
  assign done        = stateQ == ST_DONE;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> startReady); // R1

endmodule

// File: rtl/sprite_row_render.sv
module sprite_row_render
  import spr_pkg::*;
#(
  parameter int LINE_W = 64,
  parameter int ADDR_W = 24,
  parameter int X_W    = 10,
  parameter int Y_W    = 10,
  parameter int SZ_W   = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startValid,
  output logic                      startReady,
  input  logic [ADDR_W-1:0]         sprBase,
  input  logic [X_W-1:0]            sprX,
  input  logic [Y_W-1:0]            sprY,
  input  logic [SZ_W-1:0]           sprWCode,
  input  logic [SZ_W-1:0]           sprHCode,
  input  logic [2:0]                sprMode,
  input  logic                      sprFlipH,
  input  logic                      sprFlipV,
  input  logic [Y_W-1:0]            lineNum,
  output logic                      memReqValid,
  input  logic                      memReqReady,
  output logic [ADDR_W-1:0]         memReqAddr,
  input  logic                      memRspValid,
  input  logic [7:0]                memRspData,
  output logic [7:0]                palIdx,
  input  logic [15:0]               palData,
  input  logic                      palBlend,
  output logic                      lbWe,
  output logic [$clog2(LINE_W)-1:0] lbAddr,
  output logic [15:0]               lbData,
  output logic                      lbBlend,
  output logic                      done
);

  spr_strobe_t stb;
  logic hit, haveBits, lastPix;

  spr_row_ctrl uCtrl (
    .clk, .rstN, .startValid, .hit, .haveBits, .lastPix,
    .memReqReady, .memRspValid, .stb, .startReady, .memReqValid, .done
  );

  spr_row_dp #(
    .LINE_W(LINE_W), .ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W), .SZ_W(SZ_W)
  ) uDp (
    .clk, .rstN, .stb, .sprBase, .sprX, .sprY, .sprWCode, .sprHCode,
    .sprMode, .sprFlipH, .sprFlipV, .lineNum, .memRspData, .palData,
    .palBlend, .hit, .haveBits, .lastPix, .memReqAddr, .palIdx, .lbWe,
    .lbAddr, .lbData, .lbBlend
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)); // R9

endmodule

// File: tb/sprite_row_render_test.sv
module sprite_row_render_test;

  localparam int LINE_W = 64;
  localparam int ADDR_W = 24;
  localparam int X_W    = 10;
  localparam int Y_W    = 10;
  localparam int SZ_W   = 6;
  localparam int LB_AW  = $clog2(LINE_W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic startReady;
  logic [ADDR_W-1:0] sprBase = '0;
  logic [X_W-1:0] sprX = '0;
  logic [Y_W-1:0] sprY = '0;
  logic [SZ_W-1:0] sprWCode = '0;
  logic [SZ_W-1:0] sprHCode = '0;
  logic [2:0] sprMode = '0;
  logic sprFlipH = 1'b0;
  logic sprFlipV = 1'b0;
  logic [Y_W-1:0] lineNum = '0;
  logic memReqValid;
  logic memReqReady = 1'b1;
  logic [ADDR_W-1:0] memReqAddr;
  logic memRspValid = 1'b0;
  logic [7:0] memRspData = '0;
  logic [7:0] palIdx;
  logic [15:0] palData;
  logic palBlend;
  logic lbWe;
  logic [LB_AW-1:0] lbAddr;
  logic [15:0] lbData;
  logic lbBlend;
  logic done;

  always #10 clk = ~clk;

  sprite_row_render #(
    .LINE_W(LINE_W), .ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W), .SZ_W(SZ_W)
  ) uut (.*);

  // palette model: colour = {idx, idx^A5}, blend = idx bit 1
  assign palData  = {palIdx, palIdx ^ 8'hA5};
  assign palBlend = palIdx[1];

  logic [7:0] mem [0:4095];
  logic [16:0] lbMem [0:LINE_W-1];
  bit lbHit [0:LINE_W-1];
  logic [ADDR_W-1:0] reqLog [0:63];
  int reqCount = 0;
  int doneCount = 0;
  bit hs = 1'b0;
  logic [ADDR_W-1:0] hsAddr = '0;
  bit clrLb = 1'b0;
  bit stallMode = 1'b0;
  bit tog = 1'b0;
  int total = 0;
  int fails = 0;

  always @(posedge clk) begin
    hs     <= memReqValid && memReqReady;
    hsAddr <= memReqAddr;
    if (memReqValid && memReqReady) begin
      reqLog[reqCount % 64] <= memReqAddr;
      reqCount <= reqCount + 1;
    end
    if (done) doneCount <= doneCount + 1;
    if (clrLb) begin
      for (int i = 0; i < LINE_W; i++) lbHit[i] <= 1'b0;
    end else if (lbWe) begin
      lbMem[lbAddr] <= {lbBlend, lbData};
      lbHit[lbAddr] <= 1'b1;
    end
  end

  always @(negedge clk) begin
    memRspValid <= hs;
    memRspData  <= mem[hsAddr[11:0]];
    tog         <= ~tog;
    memReqReady <= stallMode ? tog : 1'b1;
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  function automatic int bppOf(input int mode);
    case (mode)
      0: return 1;
      1: return 4;
      2: return 5;
      3: return 6;
      5: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic int pixAt(input int start, input int c, input int bpp);
    int v = 0;
    for (int b = 0; b < bpp; b++) begin
      int p = c * bpp + b;
      logic [7:0] by = mem[(start + p / 8) & 4095];
      v = (v << 1) | int'(by[7 - (p % 8)]);
    end
    return v;
  endfunction

  task automatic runSprite(input string tag, input int base, input int x, input int y,
                           input int wc, input int hc, input int mode, input bit fh,
                           input bit fv, input int line, input bit stall);
    int bpp = bppOf(mode);
    int w = (wc + 1) * 8;
    int h = (hc + 1) * 8;
    int d = line - y;
    bit isHit = (d >= 0) && (d < h);
    int row = fv ? (h - 1 - d) : d;
    int stride = (wc + 1) * bpp;
    int start = base + row * stride;
    logic [16:0] expD [LINE_W];
    bit expW [LINE_W];
    int r0, d0, n, bad, badCol, badAct, badExp;
    bit seqOk;

    @(negedge clk);
    stallMode = stall;
    clrLb = 1'b1;
    @(negedge clk);
    clrLb = 1'b0;
    r0 = reqCount;
    d0 = doneCount;
    sprBase = ADDR_W'(base); sprX = X_W'(x); sprY = Y_W'(y);
    sprWCode = SZ_W'(wc); sprHCode = SZ_W'(hc); sprMode = 3'(mode);
    sprFlipH = fh; sprFlipV = fv; lineNum = Y_W'(line);
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    chk(startReady == 1'b0, {"R1 busy after accept ", tag}, int'(startReady), 0);
    n = 0;
    while (doneCount == d0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(doneCount == d0 + 1 && startReady == 1'b1, {"R10 done then idle ", tag},
        doneCount - d0, 1);

    for (int i = 0; i < LINE_W; i++) begin
      expW[i] = 1'b0;
      expD[i] = '0;
    end
    if (isHit) begin
      for (int c = 0; c < w; c++) begin
        int v = pixAt(start, c, bpp);
        int col = fh ? (x + w - 1 - c) : (x + c);
        if (col < LINE_W && !(bpp != 16 && v == 0)) begin
          expW[col] = 1'b1;
          expD[col] = (bpp == 16) ? {1'b0, 16'(v)}
                                  : {v[1], 8'(v), 8'(v) ^ 8'hA5};
        end
      end
    end
    bad = 0; badCol = 0; badAct = 0; badExp = 0;
    for (int i = 0; i < LINE_W; i++) begin
      if (lbHit[i] != expW[i] || (expW[i] && lbMem[i] != expD[i])) begin
        if (bad == 0) begin
          badCol = i;
          badAct = lbHit[i] ? int'(lbMem[i]) : -1;
          badExp = expW[i] ? int'(expD[i]) : -1;
        end
        bad++;
      end
    end
    chk(bad == 0, $sformatf("%s pixels (first bad col %0d)", tag, badCol), badAct, badExp);

    seqOk = (reqCount - r0) == (isHit ? stride : 0);
    for (int i = 0; i < reqCount - r0 && i < 64; i++)
      if (reqLog[(r0 + i) % 64] != ADDR_W'(start + i)) seqOk = 1'b0;
    chk(seqOk, {"R3 R9 read count/order ", tag}, reqCount - r0, isHit ? stride : 0);
  endtask

  task automatic testReset();
    chk(startReady == 1'b1, "R1 reset ready", int'(startReady), 1);
    chk(done == 1'b0, "R10 reset done", int'(done), 0);
    chk(memReqValid == 1'b0, "R9 reset request", int'(memReqValid), 0);
    chk(lbWe == 1'b0, "R8 reset write", int'(lbWe), 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 73 + 29);
    mem[502] = 8'h00; mem[505] = 8'h00;   // transparent 8-bit pixels
    mem[600] = 8'h00; mem[601] = 8'h00;   // zero direct pixel
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runSprite("R4 1bpp",            100,  3, 10, 0, 0, 0, 0, 0, 12, 0);
    runSprite("R7 4bpp hflip",      200, 20,  5, 1, 1, 1, 1, 0,  5, 0);
    runSprite("R4 5bpp last row",   300,  0,  0, 1, 0, 2, 0, 0,  7, 0);
    runSprite("R3 6bpp vflip",      400, 10, 30, 0, 1, 3, 0, 1, 33, 0);
    runSprite("R3 vflip top line",  700,  2, 40, 0, 0, 4, 0, 1, 40, 0);
    runSprite("R5 8bpp transparent",500, 40,  0, 0, 0, 4, 0, 0,  0, 0);
    runSprite("R6 direct 16bit",    600, 50,  0, 0, 0, 5, 0, 0,  0, 0);
    runSprite("R8 clip hflip",      800, 60,  0, 1, 0, 4, 1, 0,  3, 0);
    runSprite("R2 miss above",      900,  0, 10, 0, 0, 4, 0, 0,  4, 0);
    runSprite("R2 miss below",      900,  0, 10, 0, 0, 4, 0, 0, 18, 0);
    runSprite("R9 stall 5bpp",     1000,  8,  2, 1, 0, 2, 1, 0,  4, 1);
    runSprite("R4 mode7 as 8bpp",  1100, 30,  0, 0, 0, 7, 0, 0,  1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule